// File: doc/BRIEF.md
# Two-Master Shared-Slave Bus Arbiter and Steering Mux

This block lets two bus masters share a single slave over a pipelined address/data bus. Each master raises its own request line and is told through its own grant line when it owns the bus. A registered arbiter decides ownership. A master begins its transfer only after it sees its grant, so the address and control path switches to that master one cycle after the grant.

Write data on this bus follows its address by one clock. The write-data path therefore uses a second select register, which is the address-phase select delayed by one more cycle. When no master is selected, the steered outputs fall to zero. The slave's ready signal goes back to both masters unchanged. While the slave stalls with ready low, the grant and both select registers are frozen, so a transfer in progress is not torn apart.

Top module: `busShareTop`

## Requirements
- R1: While the active-low synchronous reset `rstN` is low, both grants are low, both selects read 2'b00, `slvAddr` and `slvWdata` are zero and `slvWrite` is low.
- R2: At most one grant is high at any time. When the bus is unowned and both masters request on the same edge, master 1 receives the grant.
- R3: A master that owns the bus keeps its grant while it holds its request, even if the other master also requests. After the owner drops its request at a ready edge, a waiting master receives the grant on that same edge.
- R4: On each edge where `hready` is high, `addrSel` takes the grant value from before that edge, encoded as 2'b00 for none, 2'b01 for master 1 and 2'b10 for master 2.
- R5: On each edge where `hready` is high, `dataSel` takes the value `addrSel` held before that edge, using the same encoding.
- R6: `slvAddr` and `slvWrite` carry the address and write flag of the master named by `addrSel`. With `addrSel` at 2'b00, they are zero and low.
- R7: `slvWdata` carries the write data of the master named by `dataSel`, and is zero when `dataSel` is 2'b00.
- R8: On an edge where `hready` is low, the grants, `addrSel` and `dataSel` keep their values, whatever the request lines do.
- R9: `readyM1` and `readyM2` both equal `hready` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqM1 | input | 1 | Bus request from master 1 |
| reqM2 | input | 1 | Bus request from master 2 |
| grantM1 | output | 1 | Bus grant to master 1 |
| grantM2 | output | 1 | Bus grant to master 2 |
| addrM1 | input | ADDR_W | Address from master 1 |
| writeM1 | input | 1 | Write flag from master 1 |
| wdataM1 | input | DATA_W | Write data from master 1 |
| addrM2 | input | ADDR_W | Address from master 2 |
| writeM2 | input | 1 | Write flag from master 2 |
| wdataM2 | input | DATA_W | Write data from master 2 |
| hready | input | 1 | Ready from the slave |
| readyM1 | output | 1 | Ready returned to master 1 |
| readyM2 | output | 1 | Ready returned to master 2 |
| slvAddr | output | ADDR_W | Steered address to the slave |
| slvWrite | output | 1 | Steered write flag to the slave |
| slvWdata | output | DATA_W | Steered write data to the slave |
| addrSel | output | 2 | Address-phase select |
| dataSel | output | 2 | Data-phase select |

## Verification
The properties assume that `hready`, the request lines and the master buses carry known values and change only between clock edges. They also assume that reset is held for at least one edge before the first check. The stimulus drives every input on the falling edge and keeps each value until the next falling edge. It also holds `hready` at a defined level during reset. The stall scenarios are there to show that the frozen state does not depend on the masters' behaviour: they drop or raise requests while `hready` is low.

// File: rtl/busShare_pkg.sv
package busShare_pkg;

  // Encoding of a master select: none, master 1, master 2.
  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_M1   = 2'b01,
    SEL_M2   = 2'b10
  } selT;

  // Strobes handed from control to datapath.
  typedef struct packed {
    selT addrSel;
    selT dataSel;
  } steerT;

  localparam int unsigned SEL_W     = 2;
  localparam int unsigned PIPE_DEPTH = 2;

endpackage

// File: rtl/grantArb.sv
module grantArb
  import busShare_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqM1,
  input  logic reqM2,
  input  logic advance,
  output selT  grantSel
);

  selT ownerQ;
  selT ownerNext;

  // The owner keeps the bus while it requests. Otherwise master 1 is
  // preferred, then master 2.
  always_comb begin
    ownerNext = ownerQ;
    if (advance) begin
      if (ownerQ == SEL_M1 && reqM1) begin
        ownerNext = SEL_M1;
      end else if (ownerQ == SEL_M2 && reqM2) begin
        ownerNext = SEL_M2;
      end else if (reqM1) begin
        ownerNext = SEL_M1;
      end else if (reqM2) begin
        ownerNext = SEL_M2;
      end else begin
        ownerNext = SEL_NONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownerQ <= SEL_NONE;
    end else begin
      ownerQ <= ownerNext;
    end
  end

  assign grantSel = ownerQ;

endmodule

// File: rtl/selPipe.sv
module selPipe
  import busShare_pkg::*;
#(
  parameter int unsigned STAGES = PIPE_DEPTH
)(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         advance,
  input  logic [SEL_W-1:0]             inSel,
  output logic [STAGES-1:0][SEL_W-1:0] stageQ
);

  // Each stage shifts by one only on cycles that advance.
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [SEL_W-1:0] srcSel;
    if (i == 0) begin : g_head
      assign srcSel = inSel;
    end else begin : g_tail
      assign srcSel = stageQ[i-1];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stageQ[i] <= '0;
      end else if (advance) begin
        stageQ[i] <= srcSel;
      end
    end
  end

endmodule

// File: rtl/arbCtrl.sv
module arbCtrl
  import busShare_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  reqM1,
  input  logic  reqM2,
  input  logic  hready,
  output logic  grantM1,
  output logic  grantM2,
  output steerT steer
);

  selT grantSel;
  logic [PIPE_DEPTH-1:0][SEL_W-1:0] pipeQ;

  grantArb arb_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqM1    (reqM1),
    .reqM2    (reqM2),
    .advance  (hready),
    .grantSel (grantSel)
  );

  selPipe #(.STAGES(PIPE_DEPTH)) pipe_i (
    .clk     (clk),
    .rstN    (rstN),
    .advance (hready),
    .inSel   (grantSel),
    .stageQ  (pipeQ)
  );

  assign grantM1       = (grantSel == SEL_M1);
  assign grantM2       = (grantSel == SEL_M2);
  assign steer.addrSel = selT'(pipeQ[0]);
  assign steer.dataSel = selT'(pipeQ[1]);

endmodule

// File: rtl/muxPath.sv
module muxPath
  import busShare_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
)(
  input  steerT              steer,
  input  logic [ADDR_W-1:0]  addrM1,
  input  logic               writeM1,
  input  logic [DATA_W-1:0]  wdataM1,
  input  logic [ADDR_W-1:0]  addrM2,
  input  logic               writeM2,
  input  logic [DATA_W-1:0]  wdataM2,
  output logic [ADDR_W-1:0]  slvAddr,
  output logic               slvWrite,
  output logic [DATA_W-1:0]  slvWdata
);

  // Address and control follow the address-phase select.
  always_comb begin
    unique case (steer.addrSel)
      SEL_M1: begin
        slvAddr  = addrM1;
        slvWrite = writeM1;
      end
      SEL_M2: begin
        slvAddr  = addrM2;
        slvWrite = writeM2;
      end
      default: begin
        slvAddr  = '0;
        slvWrite = 1'b0;
      end
    endcase
  end

  // Write data follows the data-phase select, one beat later.
  always_comb begin
    unique case (steer.dataSel)
      SEL_M1:  slvWdata = wdataM1;
      SEL_M2:  slvWdata = wdataM2;
      default: slvWdata = '0;
    endcase
  end

endmodule

// File: rtl/busShareTop.sv
module busShareTop
  import busShare_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqM1,
  input  logic              reqM2,
  output logic              grantM1,
  output logic              grantM2,
  input  logic [ADDR_W-1:0] addrM1,
  input  logic              writeM1,
  input  logic [DATA_W-1:0] wdataM1,
  input  logic [ADDR_W-1:0] addrM2,
  input  logic              writeM2,
  input  logic [DATA_W-1:0] wdataM2,
  input  logic              hready,
  output logic              readyM1,
  output logic              readyM2,
  output logic [ADDR_W-1:0] slvAddr,
  output logic              slvWrite,
  output logic [DATA_W-1:0] slvWdata,
  output logic [1:0]        addrSel,
  output logic [1:0]        dataSel
);

  steerT steer;

  arbCtrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqM1   (reqM1),
    .reqM2   (reqM2),
    .hready  (hready),
    .grantM1 (grantM1),
    .grantM2 (grantM2),
    .steer   (steer)
  );

  muxPath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) path_i (
    .steer    (steer),
    .addrM1   (addrM1),
    .writeM1  (writeM1),
    .wdataM1  (wdataM1),
    .addrM2   (addrM2),
    .writeM2  (writeM2),
    .wdataM2  (wdataM2),
    .slvAddr  (slvAddr),
    .slvWrite (slvWrite),
    .slvWdata (slvWdata)
  );

  assign readyM1 = hready;
  assign readyM2 = hready;
  assign addrSel = steer.addrSel;
  assign dataSel = steer.dataSel;

endmodule

// File: rtl/busShareChk.sv
module busShareChk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
)(
  input logic              clk,
  input logic              rstN,
  input logic              reqM1,
  input logic              reqM2,
  input logic              grantM1,
  input logic              grantM2,
  input logic [ADDR_W-1:0] addrM1,
  input logic              writeM1,
  input logic [DATA_W-1:0] wdataM1,
  input logic [ADDR_W-1:0] addrM2,
  input logic              writeM2,
  input logic [DATA_W-1:0] wdataM2,
  input logic              hready,
  input logic              readyM1,
  input logic              readyM2,
  input logic [ADDR_W-1:0] slvAddr,
  input logic              slvWrite,
  input logic [DATA_W-1:0] slvWdata,
  input logic [1:0]        addrSel,
  input logic [1:0]        dataSel
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rstN |=> (!grantM1 && !grantM2 && addrSel == 2'b00 && dataSel == 2'b00));

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({grantM2, grantM1}));

  // R2
  m1_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hready && !grantM1 && !grantM2 && reqM1) |=> grantM1);

  // R3
  m1_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hready && grantM1 && reqM1) |=> grantM1);

  // R3
  m2_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hready && grantM2 && reqM2) |=> grantM2);

  // R4
  addr_sel_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    hready |=> (addrSel == $past({grantM2, grantM1})));

  // R5
  data_sel_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    hready |=> (dataSel == $past(addrSel)));

  // R6
  addr_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrSel == 2'b00) |-> (slvAddr == '0 && !slvWrite));

  // R6
  addr_m2_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrSel == 2'b10) |-> (slvAddr == addrM2 && slvWrite == writeM2));

  // R7
  wdata_m1_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataSel == 2'b01) |-> (slvWdata == wdataM1));

  // R8
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rstN)
    !hready |=> ($stable({grantM2, grantM1}) && $stable(addrSel) && $stable(dataSel)));

  // R9
  always_comb begin
    ready_fanout_chk: assert (readyM1 == hready && readyM2 == hready);
  end

  logic unusedSigs;
  assign unusedSigs = ^{addrM1, writeM1, wdataM2};

endmodule

bind busShareTop busShareChk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .reqM1(reqM1), .reqM2(reqM2),
  .grantM1(grantM1), .grantM2(grantM2),
  .addrM1(addrM1), .writeM1(writeM1), .wdataM1(wdataM1),
  .addrM2(addrM2), .writeM2(writeM2), .wdataM2(wdataM2),
  .hready(hready), .readyM1(readyM1), .readyM2(readyM2),
  .slvAddr(slvAddr), .slvWrite(slvWrite), .slvWdata(slvWdata),
  .addrSel(addrSel), .dataSel(dataSel)
);

// File: tb/busShareTop_tb_top.sv
`timescale 1ns/100ps
module busShareTop_tb_top;

  localparam int unsigned AW = 32;
  localparam int unsigned DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqM1 = 1'b0, reqM2 = 1'b0;
  logic grantM1, grantM2;
  logic [AW-1:0] addrM1 = '0, addrM2 = '0;
  logic writeM1 = 1'b0, writeM2 = 1'b0;
  logic [DW-1:0] wdataM1 = '0, wdataM2 = '0;
  logic hready = 1'b1;
  logic readyM1, readyM2;
  logic [AW-1:0] slvAddr;
  logic slvWrite;
  logic [DW-1:0] slvWdata;
  logic [1:0] addrSel, dataSel;

  always #2 clk = ~clk;

  busShareTop #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .reqM1(reqM1), .reqM2(reqM2),
    .grantM1(grantM1), .grantM2(grantM2),
    .addrM1(addrM1), .writeM1(writeM1), .wdataM1(wdataM1),
    .addrM2(addrM2), .writeM2(writeM2), .wdataM2(wdataM2),
    .hready(hready), .readyM1(readyM1), .readyM2(readyM2),
    .slvAddr(slvAddr), .slvWrite(slvWrite), .slvWdata(slvWdata),
    .addrSel(addrSel), .dataSel(dataSel)
  );

  typedef struct {
    logic [1:0]    grant;
    logic [1:0]    aSel;
    logic [1:0]    dSel;
    logic [AW-1:0] addr;
    logic          wr;
    logic [DW-1:0] wdata;
    logic          rdy;
    logic          stalled;
  } expT;

  expT sbQ[$];
  int nChecks = 0;
  int nFail = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit reported = 1'b0;

  // Reference state, built from the requirements.
  logic [1:0] mGrant = 2'b00, mAs = 2'b00, mDs = 2'b00;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected result.
  task automatic step(input logic r1, input logic r2, input logic rdy);
    expT e;
    logic [1:0] nxt;
    @(negedge clk);
    cyc++;
    reqM1   = r1;
    reqM2   = r2;
    hready  = rdy;
    addrM1  = 32'h1000_0000 + cyc;
    addrM2  = 32'h2000_0000 + cyc;
    wdataM1 = 32'hA100_0000 + cyc;
    wdataM2 = 32'hB200_0000 + cyc;
    writeM1 = cyc[0];
    writeM2 = ~cyc[0];
    if (rdy) begin
      if (mGrant == 2'b01 && r1)      nxt = 2'b01;
      else if (mGrant == 2'b10 && r2) nxt = 2'b10;
      else if (r1)                    nxt = 2'b01;
      else if (r2)                    nxt = 2'b10;
      else                            nxt = 2'b00;
      mDs    = mAs;
      mAs    = mGrant;
      mGrant = nxt;
    end
    @(posedge clk);
    #0.5;
    e.grant   = mGrant;
    e.aSel    = mAs;
    e.dSel    = mDs;
    e.addr    = (mAs == 2'b01) ? addrM1 : (mAs == 2'b10) ? addrM2 : '0;
    e.wr      = (mAs == 2'b01) ? writeM1 : (mAs == 2'b10) ? writeM2 : 1'b0;
    e.wdata   = (mDs == 2'b01) ? wdataM1 : (mDs == 2'b10) ? wdataM2 : '0;
    e.rdy     = rdy;
    e.stalled = !rdy;
    sbQ.push_back(e);
  endtask

  // Monitor: compares the design against queued expectations.
  always @(posedge clk) begin
    #1;
    while (sbQ.size() > 0) begin
      expT e;
      e = sbQ.pop_front();
      check({grantM2, grantM1} == e.grant, e.stalled ? "R8 grant" : "R2 R3 grant",
            {62'd0, grantM2, grantM1}, {62'd0, e.grant});
      check(addrSel == e.aSel, e.stalled ? "R8 addrSel" : "R4 addrSel",
            {62'd0, addrSel}, {62'd0, e.aSel});
      check(dataSel == e.dSel, e.stalled ? "R8 dataSel" : "R5 dataSel",
            {62'd0, dataSel}, {62'd0, e.dSel});
      check(slvAddr == e.addr && slvWrite == e.wr, "R6 addr/write",
            {31'd0, slvWrite, slvAddr}, {31'd0, e.wr, e.addr});
      check(slvWdata == e.wdata, "R7 wdata", {32'd0, slvWdata}, {32'd0, e.wdata});
      check(readyM1 == e.rdy && readyM2 == e.rdy, "R9 ready",
            {62'd0, readyM2, readyM1}, {62'd0, e.rdy, e.rdy});
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
      $finish;
    end
  end

  initial begin
    // R1: reset state with busy masters.
    reqM1 = 1'b1; reqM2 = 1'b1; hready = 1'b1;
    addrM1 = 32'hDEAD_0001; addrM2 = 32'hDEAD_0002;
    wdataM1 = 32'hBEEF_0001; wdataM2 = 32'hBEEF_0002;
    writeM1 = 1'b1; writeM2 = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!grantM1 && !grantM2, "R1 grants", {62'd0, grantM2, grantM1}, 64'd0);
    check(addrSel == 2'b00 && dataSel == 2'b00, "R1 selects",
          {60'd0, addrSel, dataSel}, 64'd0);
    check(slvAddr == '0 && !slvWrite && slvWdata == '0, "R1 outputs",
          {slvAddr, slvWdata}, 64'd0);
    reqM1 = 1'b0; reqM2 = 1'b0;
    rstN = 1'b1;

    step(0, 0, 1);
    repeat (3) step(1, 0, 1);      // master 1 alone
    repeat (3) step(1, 1, 1);      // R3: master 1 keeps bus
    repeat (3) step(0, 1, 1);      // handover to master 2
    repeat (3) step(1, 1, 0);      // R8: stall freezes everything
    step(0, 1, 0);
    step(1, 0, 1);                 // master 2 gone, master 1 takes over
    repeat (3) step(0, 0, 1);      // drain to idle
    step(1, 1, 1);                 // R2: simultaneous from idle
    repeat (3) step(0, 0, 1);
    step(0, 1, 1);                 // master 2 alone
    repeat (2) step(0, 1, 0);      // stall mid pipeline
    repeat (4) step(0, 0, 1);
    step(0, 1, 1);
    step(1, 0, 1);                 // R3: owner drops while other waits
    step(1, 1, 0);
    repeat (4) step(0, 0, 1);

    repeat (2) @(posedge clk);
    #2;
    done = 1'b1;
    report();
    $finish;
  end

endmodule